// File: doc/BRIEF.md
# Associative Minimum Spanning Tree Engine

This engine builds a minimum spanning tree over an undirected weighted graph of up to `N_NODES` vertices. Every vertex lives in a cell of its own. A cell holds one row of the adjacency matrix, a three-state membership tag (waiting, candidate, settled), its best known connection weight and the index of its tree parent. A single sequencer broadcasts to all cells at once. In each pass a global minimum unit finds the cheapest candidate cell. That cell is settled, and every other cell updates itself in the same clock edge against the newly settled vertex. No lists, queues or pointers are kept. The tree grows by one edge per clock.

Adjacency rows come in through a valid/ready stream, one full row per beat. The row is written into the cell named by the beat. `ld_ready` is high whenever the engine is not running, so a sender may hold `ld_valid` with stable data until it sees `ld_ready`. While a run is in progress `ld_ready` is low and beats are neither taken nor lost. A one-cycle `start` pulse with a root index begins a run. The parent of every vertex is then presented in parallel on `parents`. `done` flags that the graph was spanned, and `disconnected` flags that some vertex could not be reached.

Top module: `mst_assoc_engine`

## Requirements
- R1: After reset `busy`, `done` and `disconnected` are low, `ld_ready` is high and every vertex reports its own index as parent.
- R2: A row beat is taken on a clock edge with `ld_valid` and `ld_ready` both high. Lane j of `ld_row` (bits j*8+7..j*8) is the weight from vertex `ld_node` to vertex j. `ld_ready` is low while `busy` is high, and beats offered then leave the stored matrix unchanged.
- R3: A start taken while idle sets the root to settled with itself as parent. Every other vertex with a finite edge to the root becomes a candidate with the root as parent and that weight as best. All remaining vertices wait, with their own index as parent.
- R4: `busy` rises on the edge that takes the start. On a connected graph of n vertices it stays high for exactly n cycles, settling one vertex per cycle. `done` rises as `busy` falls and stays high until the next start.
- R5: When a vertex settles, each candidate whose edge to it is strictly lighter than its best adopts that weight and takes the settled vertex as parent. Waiting vertices with a finite edge to it become candidates with it as parent.
- R6: Among candidates of equal best weight, the lowest index settles first.
- R7: The weight 255 (all ones) means no edge. Every weight from 0 to 254 is a real edge.
- R8: If no candidate remains while a vertex still waits, `busy` falls, `disconnected` rises, `done` stays low, and the unreached vertices keep their own index as parent.
- R9: A start pulse while `busy` is high is ignored.
- R10: At the end of a run, `parents` holds the spanning tree produced by the rules R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Row beat offered |
| ld_ready | output | 1 | Row beat can be taken (engine idle) |
| ld_node | input | 3 | Vertex whose row is carried |
| ld_row | input | 64 | Eight 8-bit weights, lane j to vertex j |
| start | input | 1 | Begin a run (one-cycle pulse) |
| root | input | 3 | Root vertex for the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run spanned the graph |
| disconnected | output | 1 | Last run found an unreachable vertex |
| parents | output | 24 | Parent index of vertex i in bits 3i+2..3i |

## Verification
The hardest cases to reach from the ports are two. The first is a settled vertex that improves a candidate already offered by an earlier vertex. The second is an equal-weight tie that decides which vertex settles first. A hand-built graph produces both, and the outcome differs if either rule is broken. A behavioural reference model follows randomly weighted symmetric graphs clock by clock, with absent edges mixed in. Further stimulus covers a start pulse and row beats arriving mid-run, and a sparse graph that leaves vertices unreachable.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    TAG_WAIT = 2'd0,
    TAG_CAND = 2'd1,
    TAG_DONE = 2'd2
  } tag_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_t;
endpackage

// File: rtl/mst_cell.sv
module mst_cell #(
  parameter int N_NODES = 8,
  parameter int W_BITS  = 8,
  parameter int MY_ID   = 0,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [N_NODES*W_BITS-1:0] wr_row,
  input  logic                      init,
  input  logic [IDX_W-1:0]          root,
  input  logic                      step,
  input  logic [IDX_W-1:0]          next_id,
  output mst_pkg::tag_t             tag,
  output logic [W_BITS-1:0]         best,
  output logic [IDX_W-1:0]          parent
);
  import mst_pkg::*;
  localparam logic [W_BITS-1:0] NO_EDGE = '1;
  localparam logic [IDX_W-1:0]  ME      = MY_ID[IDX_W-1:0];

  logic [N_NODES*W_BITS-1:0] row_q;
  logic [W_BITS-1:0] w_root, w_next;

  assign w_root = row_q[root*W_BITS +: W_BITS];
  assign w_next = row_q[next_id*W_BITS +: W_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '1;
      tag    <= TAG_DONE;
      best   <= NO_EDGE;
      parent <= ME;
    end else begin
      if (wr_en) row_q <= wr_row;
      if (init) begin
        if (root == ME) begin
          tag    <= TAG_DONE;
          best   <= NO_EDGE;
          parent <= ME;
        end else if (w_root != NO_EDGE) begin
          tag    <= TAG_CAND;
          best   <= w_root;
          parent <= root;
        end else begin
          tag    <= TAG_WAIT;
          best   <= NO_EDGE;
          parent <= ME;
        end
      end else if (step) begin
        if (next_id == ME) begin
          tag <= TAG_DONE;
        end else if (tag == TAG_CAND && w_next < best) begin
          best   <= w_next;
          parent <= next_id;
        end else if (tag == TAG_WAIT && w_next != NO_EDGE) begin
          tag    <= TAG_CAND;
          best   <= w_next;
          parent <= next_id;
        end
      end
    end
  end
endmodule

// File: rtl/mst_argmin.sv
module mst_argmin #(
  parameter int N_NODES = 8,
  parameter int W_BITS  = 8,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic [N_NODES-1:0]        sel,
  input  logic [N_NODES*W_BITS-1:0] keys,
  output logic                      any,
  output logic [IDX_W-1:0]          idx
);
  logic [W_BITS-1:0] cur;

  always_comb begin
    any = 1'b0;
    idx = '0;
    cur = '1;
    for (int i = 0; i < N_NODES; i++) begin
      if (sel[i] && (!any || keys[i*W_BITS +: W_BITS] < cur)) begin
        any = 1'b1;
        idx = i[IDX_W-1:0];
        cur = keys[i*W_BITS +: W_BITS];
      end
    end
  end
endmodule

// File: rtl/mst_assoc_engine.sv
module mst_assoc_engine #(
  parameter int N_NODES = 8,
  parameter int W_BITS  = 8,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  output logic                      ld_ready,
  input  logic [IDX_W-1:0]          ld_node,
  input  logic [N_NODES*W_BITS-1:0] ld_row,
  input  logic                      start,
  input  logic [IDX_W-1:0]          root,
  output logic                      busy,
  output logic                      done,
  output logic                      disconnected,
  output logic [N_NODES*IDX_W-1:0]  parents
);
  import mst_pkg::*;

  seq_t                      seq_q;
  logic                      init, step, any_cand;
  logic [IDX_W-1:0]          next_id;
  logic [N_NODES-1:0]        cand_vec, wait_vec;
  logic [N_NODES*W_BITS-1:0] best_flat;

  assign busy     = (seq_q == SEQ_RUN);
  assign ld_ready = !busy;
  assign init     = start && !busy;
  assign step     = busy && any_cand;

  for (genvar g = 0; g < N_NODES; g++) begin : g_cell
    tag_t              tag_g;
    logic [W_BITS-1:0] best_g;
    logic [IDX_W-1:0]  par_g;

    mst_cell #(.N_NODES(N_NODES), .W_BITS(W_BITS), .MY_ID(g)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ld_valid && ld_ready && ld_node == g[IDX_W-1:0]),
      .wr_row  (ld_row),
      .init    (init),
      .root    (root),
      .step    (step),
      .next_id (next_id),
      .tag     (tag_g),
      .best    (best_g),
      .parent  (par_g)
    );

    assign cand_vec[g]                    = (tag_g == TAG_CAND);
    assign wait_vec[g]                    = (tag_g == TAG_WAIT);
    assign best_flat[g*W_BITS +: W_BITS]  = best_g;
    assign parents[g*IDX_W +: IDX_W]      = par_g;
  end

  mst_argmin #(.N_NODES(N_NODES), .W_BITS(W_BITS)) u_min (
    .sel  (cand_vec),
    .keys (best_flat),
    .any  (any_cand),
    .idx  (next_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q        <= SEQ_IDLE;
      done         <= 1'b0;
      disconnected <= 1'b0;
    end else if (init) begin
      seq_q        <= SEQ_RUN;
      done         <= 1'b0;
      disconnected <= 1'b0;
    end else if (busy && !any_cand) begin
      seq_q <= SEQ_IDLE;
      if (|wait_vec) disconnected <= 1'b1;
      else           done         <= 1'b1;
    end
  end
endmodule

// File: rtl/mst_assoc_engine_chk.sv
module mst_assoc_engine_chk #(
  parameter int N_NODES = 8,
  parameter int W_BITS  = 8,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ld_valid,
  input logic                      ld_ready,
  input logic [IDX_W-1:0]          ld_node,
  input logic [N_NODES*W_BITS-1:0] ld_row,
  input logic                      start,
  input logic [IDX_W-1:0]          root,
  input logic                      busy,
  input logic                      done,
  input logic                      disconnected,
  input logic [N_NODES*IDX_W-1:0]  parents
);
  logic [IDX_W-1:0] root_q;
  int unsigned      run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_q  <= '0;
      run_cnt <= 0;
    end else begin
      if (start && !busy) root_q <= root;
      run_cnt <= busy ? run_cnt + 1 : 0;
    end
  end

  assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);
  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < N_NODES);
  assert_done_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && disconnected));
  assert_root_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> parents[root_q*IDX_W +: IDX_W] == root_q);
  assert_run_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind mst_assoc_engine mst_assoc_engine_chk #(.N_NODES(N_NODES), .W_BITS(W_BITS)) u_chk (.*);

// File: tb/tb_mst_assoc_engine.sv
module tb_mst_assoc_engine;
  localparam int N = 8;
  localparam int W = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [IW-1:0] ld_node = '0;
  logic [N*W-1:0] ld_row = '0;
  logic start = 1'b0;
  logic [IW-1:0] root = '0;
  logic ld_ready, busy, done, disconnected;
  logic [N*IW-1:0] parents;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  int g_adj [N][N];
  int m_adj [N][N];
  int m_tag [N];
  int m_best [N];
  int m_par [N];
  bit m_busy, m_done, m_disc;

  always #5 clk = ~clk;

  mst_assoc_engine dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_node(ld_node), .ld_row(ld_row), .start(start), .root(root),
    .busy(busy), .done(done), .disconnected(disconnected), .parents(parents)
  );

  // reference model: tags 0 wait, 1 candidate, 2 settled
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) m_adj[i][j] = 255;
        m_tag[i] = 2; m_best[i] = 255; m_par[i] = i;
      end
      m_busy = 0; m_done = 0; m_disc = 0;
    end else begin
      bit was_busy;
      int y;
      was_busy = m_busy;
      if (start && !was_busy) begin
        for (int i = 0; i < N; i++) begin
          if (i == root) begin m_tag[i] = 2; m_best[i] = 255; m_par[i] = i; end
          else if (m_adj[i][root] != 255) begin
            m_tag[i] = 1; m_best[i] = m_adj[i][root]; m_par[i] = root;
          end else begin m_tag[i] = 0; m_best[i] = 255; m_par[i] = i; end
        end
        m_busy = 1; m_done = 0; m_disc = 0;
      end else if (was_busy) begin
        y = -1;
        for (int i = 0; i < N; i++)
          if (m_tag[i] == 1 && (y < 0 || m_best[i] < m_best[y])) y = i;
        if (y >= 0) begin
          m_tag[y] = 2;
          for (int i = 0; i < N; i++) begin
            if (i == y) continue;
            if (m_tag[i] == 1 && m_adj[i][y] < m_best[i]) begin
              m_best[i] = m_adj[i][y]; m_par[i] = y;
            end else if (m_tag[i] == 0 && m_adj[i][y] != 255) begin
              m_tag[i] = 1; m_best[i] = m_adj[i][y]; m_par[i] = y;
            end
          end
        end else begin
          bit any_wait;
          any_wait = 0;
          for (int i = 0; i < N; i++) if (m_tag[i] == 0) any_wait = 1;
          m_busy = 0;
          if (any_wait) m_disc = 1; else m_done = 1;
        end
      end
      if (ld_valid && !was_busy)
        for (int j = 0; j < N; j++) m_adj[ld_node][j] = ld_row[j*W +: W];
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare against the model on every falling edge after reset
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4", "busy", busy, m_busy);
      chk("R4", "done", done, m_done);
      chk("R8", "disconnected", disconnected, m_disc);
      chk("R2", "ld_ready", ld_ready, !m_busy);
      for (int i = 0; i < N; i++)
        chk("R10", $sformatf("parent[%0d]", i), parents[i*IW +: IW], m_par[i]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic load_graph();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_node = i[IW-1:0];
      for (int j = 0; j < N; j++) ld_row[j*W +: W] = g_adj[i][j][W-1:0];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic clear_graph();
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) g_adj[i][j] = 255;
  endtask

  task automatic edge_set(input int a, input int b, input int w);
    g_adj[a][b] = w; g_adj[b][a] = w;
  endtask

  task automatic run(input int r);
    @(negedge clk);
    start = 1'b1; root = r[IW-1:0];
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int par(input int i);
    return parents[i*IW +: IW];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "disconnected", disconnected, 0);
    chk("R1", "ld_ready", ld_ready, 1);
    for (int i = 0; i < N; i++) chk("R1", "parent", par(i), i);

    // R5 and R6: tie at the root and a later relaxation; R7 with weight 254
    clear_graph();
    edge_set(0, 1, 4); edge_set(0, 2, 4); edge_set(1, 3, 2); edge_set(2, 3, 2);
    for (int k = 4; k < N; k++) edge_set(3, k, 254);
    load_graph();
    @(negedge clk);
    start = 1'b1; root = 3'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R3", "root parent", par(0), 0);
    chk("R3", "candidate parent", par(1), 0);
    chk("R3", "waiting parent", par(3), 3);
    @(negedge clk);
    // R9: start while busy, different root
    start = 1'b1; root = 3'd5;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk("R4", "done after span", done, 1);
    chk("R6", "tie lowest index first", par(3), 1);
    chk("R5", "relaxed parent", par(2), 3);
    chk("R9", "root kept", par(0), 0);
    chk("R7", "weight 254 is an edge", par(7), 3);

    // R8: only one edge from the root
    clear_graph();
    edge_set(0, 1, 9);
    load_graph();
    run(0);
    chk("R8", "disconnected", disconnected, 1);
    chk("R8", "done low", done, 0);
    chk("R8", "reached", par(1), 0);
    chk("R8", "unreached", par(5), 5);

    // random symmetric graphs, with beats offered mid-run (R2)
    for (int t = 0; t < 30; t++) begin
      clear_graph();
      for (int a = 0; a < N; a++)
        for (int b = a + 1; b < N; b++)
          edge_set(a, b, ($urandom % 4 == 0) ? 255 : ($urandom % 255));
      load_graph();
      @(negedge clk);
      start = 1'b1; root = $urandom % N;
      @(negedge clk);
      start = 1'b0;
      ld_valid = 1'b1; ld_node = $urandom % N; ld_row = '0;
      while (busy) @(negedge clk);
      ld_valid = 1'b0;
      @(negedge clk);
      run($urandom % N);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule